// File: doc/BRIEF.md
# Clock-Gated Virtual Channel Buffer

This block holds the virtual-channel queues of one router input port. Each channel is a small FIFO of flits with its own occupancy counter, a status state machine that derives full and empty flags from that counter, and a gating controller. The gating controller turns the channel's storage clock enable on or off from those flags. An incoming flit names a target channel. If that channel is full, the flit is steered to another channel of the same port that has room. The switch arbiter pops a channel by raising that channel's grant bit.

The gate closes when a channel becomes empty, and also when it becomes full. Only an accepted write reopens it. Flits parked in a channel while they wait for the switch therefore draw no storage clock. A read pulses the enable for its own cycle only. Gating is modelled as a synchronous clock enable on the storage, pointer and counter registers. The enable of each channel is brought out so its gating can be observed.

Top module: `vc_gated_buffer`

## Requirements
- R1: While rst_n is low, every channel reads empty, none reads full and every clock enable is low; the reset acts asynchronously. After rst_n rises, a write is ignored at the first two rising clock edges and accepted from the third.
- R2: A write to a channel that is not full is stored at the next clock edge. Each channel returns flits in arrival order, and its head output shows the oldest stored flit.
- R3: A grant to a non-empty channel removes its head flit at the next edge. A grant to an empty channel changes nothing.
- R4: The full flag is set exactly when a channel holds DEPTH flits, and the empty flag exactly when it holds none. Both flags are low for any count in between, and both follow the edge that changes the count.
- R5: A channel that is empty or full, and sees neither an accepted write nor an accepted read in the current cycle, has its clock enable low.
- R6: An accepted write to a gated channel raises that channel's clock enable in the same cycle, and the flit is stored at that edge.
- R7: A write whose target channel is full goes to the first non-full channel found by counting upward from the target and wrapping from the highest index to 0. The full target keeps its enable low.
- R8: A write arriving while every channel is full is discarded and leaves all channel contents unchanged.
- R9: A write and a read in the same cycle on a channel holding between 1 and DEPTH-1 flits leave its count unchanged, and the channel stays awake afterwards.
- R10: A read alone never wakes a gated channel. A read from a full channel raises the enable only in the read cycle, and the channel then stays gated until a write.
- R11: A channel woken by a write keeps its enable high while idle, until its count reaches 0 or DEPTH.
- R12: While a channel's enable is low, its head flit and flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming flit is valid this cycle |
| in_vc | input | $clog2(NUM_VC) | Target channel of the incoming flit |
| in_flit | input | FLIT_W | Incoming flit |
| rd_grant | input | NUM_VC | Per-channel pop request from the switch arbiter |
| head_flit | output | NUM_VC*FLIT_W | Oldest flit of each channel, channel v at bits v*FLIT_W upward |
| vc_full | output | NUM_VC | Channel holds DEPTH flits |
| vc_empty | output | NUM_VC | Channel holds no flit |
| vc_clk_en | output | NUM_VC | Per-channel storage clock enable, for observation |

## Verification
A gate state that disagrees with the occupancy shows on vc_clk_en in the same cycle. An enable left high on a parked full or empty channel, or left low under a write, is visible before the clock edge that should store the flit. A pointer or storage update made while gated shows on head_flit one edge later. A wrong count shows as a full or empty flag that appears one write too early or too late. A steering fault shows a flit in the wrong channel's head when the channels are drained, or a full target that unexpectedly wakes.

// File: rtl/vcbuf_pkg.sv
package vcbuf_pkg;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_EMPTY = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FULL  = 2'd3
  } vc_stat_e;

  typedef enum logic [1:0] {
    GT_INIT  = 2'd0,
    GT_GATED = 2'd1,
    GT_AWAKE = 2'd2
  } gate_st_e;

endpackage

// File: rtl/vc_slot_fifo.sv
module vc_slot_fifo #(
  parameter int FLIT_W = 18,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              push,
  input  logic              pop,
  input  logic [FLIT_W-1:0] din,
  output logic [FLIT_W-1:0] head
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + PTR_W'(1);
    if (pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en && push) mem[wr_ptr_q] <= din;
  end

  assign head = mem[rd_ptr_q];

endmodule

// File: rtl/vc_status_fsm.sv
module vc_status_fsm
  import vcbuf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic full,
  output logic empty,
  output logic bound_n
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  vc_stat_e         st_q, st_d;
  logic             upd;

  assign upd = push | pop;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  assign bound_n = (cnt_d == '0) || (cnt_d == CAP);

  always_comb begin
    st_d = st_q;
    if (upd) begin
      if (cnt_d == CAP)     st_d = ST_FULL;
      else if (cnt_d == '0) st_d = ST_EMPTY;
      else                  st_d = ST_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= ST_INIT;
    end else if (upd) begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  assign full  = (st_q == ST_FULL);
  assign empty = (st_q == ST_INIT) || (st_q == ST_EMPTY);

endmodule

// File: rtl/vc_gate_ctrl.sv
module vc_gate_ctrl
  import vcbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  logic bound_n,
  output logic clk_en
);

  gate_st_e g_q, g_d;

  always_comb begin
    g_d = g_q;
    unique case (g_q)
      GT_INIT:  if (push) g_d = bound_n ? GT_GATED : GT_AWAKE;
      GT_AWAKE: if ((push || pop) && bound_n) g_d = GT_GATED;
      GT_GATED: if (push && !bound_n) g_d = GT_AWAKE;
      default:  g_d = GT_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g_q <= GT_INIT;
    else        g_q <= g_d;
  end

  assign clk_en = (g_q == GT_AWAKE) || push || pop;

endmodule

// File: rtl/vc_write_steer.sv
module vc_write_steer #(
  parameter int NUM_VC = 4
) (
  input  logic                      in_valid,
  input  logic [$clog2(NUM_VC)-1:0] in_vc,
  input  logic [NUM_VC-1:0]         vc_full,
  output logic [NUM_VC-1:0]         push_oh
);

  always_comb begin
    logic found;
    found   = 1'b0;
    push_oh = '0;
    for (int k = 0; k < NUM_VC; k++) begin
      int idx;
      idx = (int'(in_vc) + k) % NUM_VC;
      if (in_valid && !found && !vc_full[idx]) begin
        push_oh[idx] = 1'b1;
        found        = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vc_gated_buffer.sv
module vc_gated_buffer #(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 18,
  parameter int DEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [$clog2(NUM_VC)-1:0] in_vc,
  input  logic [FLIT_W-1:0]         in_flit,
  input  logic [NUM_VC-1:0]         rd_grant,
  output logic [NUM_VC*FLIT_W-1:0]  head_flit,
  output logic [NUM_VC-1:0]         vc_full,
  output logic [NUM_VC-1:0]         vc_empty,
  output logic [NUM_VC-1:0]         vc_clk_en
);

  logic rst_s1_q, rst_q_n;
  logic [NUM_VC-1:0] push_oh;
  logic [NUM_VC-1:0] pop_v;
  logic [NUM_VC-1:0] bound_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q_n  <= rst_s1_q;
    end
  end

  vc_write_steer #(.NUM_VC(NUM_VC)) u_steer (
    .in_valid (in_valid),
    .in_vc    (in_vc),
    .vc_full  (vc_full),
    .push_oh  (push_oh)
  );

  assign pop_v = rd_grant & ~vc_empty;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vc_status_fsm #(.DEPTH(DEPTH)) u_stat (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .push    (push_oh[v]),
      .pop     (pop_v[v]),
      .full    (vc_full[v]),
      .empty   (vc_empty[v]),
      .bound_n (bound_v[v])
    );

    vc_gate_ctrl u_gate (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .push    (push_oh[v]),
      .pop     (pop_v[v]),
      .bound_n (bound_v[v]),
      .clk_en  (vc_clk_en[v])
    );

    vc_slot_fifo #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_q_n),
      .en    (vc_clk_en[v]),
      .push  (push_oh[v]),
      .pop   (pop_v[v]),
      .din   (in_flit),
      .head  (head_flit[v*FLIT_W +: FLIT_W])
    );
  end

endmodule

// File: rtl/vc_gated_buffer_chk.sv
module vc_gated_buffer_chk #(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 18
) (
  input logic                      clk,
  input logic                      rst_q_n,
  input logic                      in_valid,
  input logic [$clog2(NUM_VC)-1:0] in_vc,
  input logic [NUM_VC-1:0]         rd_grant,
  input logic [NUM_VC*FLIT_W-1:0]  head_flit,
  input logic [NUM_VC-1:0]         vc_full,
  input logic [NUM_VC-1:0]         vc_empty,
  input logic [NUM_VC-1:0]         vc_clk_en
);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_q_n)
      !(vc_full[v] && vc_empty[v])); // R4

    AST_GATED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
      (vc_full[v] || vc_empty[v]) && !rd_grant[v] && !in_valid |-> !vc_clk_en[v]); // R5

    AST_WAKE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
      vc_empty[v] && in_valid && (int'(in_vc) == v) |-> vc_clk_en[v]); // R6

    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_q_n)
      vc_empty[v] && in_valid && (int'(in_vc) == v) |=> !vc_empty[v]); // R2

    AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_q_n)
      !vc_clk_en[v] |=> $stable(head_flit[v*FLIT_W +: FLIT_W]) && $stable(vc_full[v])
                        && $stable(vc_empty[v])); // R12

    AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rst_q_n)
      vc_empty[v] && !in_valid |=> vc_empty[v]); // R3
  end

  AST_ALL_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (&vc_full) && (rd_grant == '0) |=> (&vc_full)); // R8

endmodule

bind vc_gated_buffer vc_gated_buffer_chk #(.NUM_VC(NUM_VC), .FLIT_W(FLIT_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .in_vc     (in_vc),
  .rd_grant  (rd_grant),
  .head_flit (head_flit),
  .vc_full   (vc_full),
  .vc_empty  (vc_empty),
  .vc_clk_en (vc_clk_en)
);

// File: tb/vc_gated_buffer_tb.sv
module vc_gated_buffer_tb;

  localparam int NV = 4;
  localparam int FW = 18;

  typedef struct packed {
    logic        wv;
    logic [1:0]  wc;
    logic [17:0] wf;
    logic [3:0]  gr;
    logic [3:0]  en;
    logic [3:0]  fu;
    logic [3:0]  em;
    logic        hk;
    logic [1:0]  hv;
    logic [17:0] hf;
  } vec_t;

  localparam vec_t TBL [18] = '{
    '{1'b1, 2'd0, 18'h0A001, 4'h0, 4'h1, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A001},
    '{1'b0, 2'd0, 18'h00000, 4'h0, 4'h1, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A001},
    '{1'b1, 2'd0, 18'h0A002, 4'h0, 4'h1, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A001},
    '{1'b1, 2'd0, 18'h0A003, 4'h0, 4'h1, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A001},
    '{1'b1, 2'd0, 18'h0A004, 4'h0, 4'h1, 4'h1, 4'hE, 1'b1, 2'd0, 18'h0A001},
    '{1'b0, 2'd0, 18'h00000, 4'h0, 4'h0, 4'h1, 4'hE, 1'b1, 2'd0, 18'h0A001},
    '{1'b1, 2'd0, 18'h0B001, 4'h0, 4'h2, 4'h1, 4'hC, 1'b1, 2'd1, 18'h0B001},
    '{1'b0, 2'd0, 18'h00000, 4'h1, 4'h3, 4'h0, 4'hC, 1'b1, 2'd0, 18'h0A002},
    '{1'b0, 2'd0, 18'h00000, 4'h0, 4'h2, 4'h0, 4'hC, 1'b1, 2'd0, 18'h0A002},
    '{1'b0, 2'd0, 18'h00000, 4'h2, 4'h2, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A002},
    '{1'b0, 2'd0, 18'h00000, 4'h0, 4'h0, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A002},
    '{1'b0, 2'd0, 18'h00000, 4'h4, 4'h0, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A002},
    '{1'b1, 2'd0, 18'h0A005, 4'h1, 4'h1, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A003},
    '{1'b0, 2'd0, 18'h00000, 4'h0, 4'h1, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A003},
    '{1'b0, 2'd0, 18'h00000, 4'h1, 4'h1, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A004},
    '{1'b0, 2'd0, 18'h00000, 4'h1, 4'h1, 4'h0, 4'hE, 1'b1, 2'd0, 18'h0A005},
    '{1'b0, 2'd0, 18'h00000, 4'h1, 4'h1, 4'h0, 4'hF, 1'b0, 2'd0, 18'h00000},
    '{1'b0, 2'd0, 18'h00000, 4'h0, 4'h0, 4'h0, 4'hF, 1'b0, 2'd0, 18'h00000}
  };

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [1:0]     in_vc;
  logic [FW-1:0]  in_flit;
  logic [NV-1:0]  rd_grant;
  logic [NV*FW-1:0] head_flit;
  logic [NV-1:0]  vc_full;
  logic [NV-1:0]  vc_empty;
  logic [NV-1:0]  vc_clk_en;

  int   checks;
  int   failures;
  logic done;
  logic [3:0] en_pre;

  vc_gated_buffer #(.NUM_VC(NV), .FLIT_W(FW), .DEPTH(4)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vc     (in_vc),
    .in_flit   (in_flit),
    .rd_grant  (rd_grant),
    .head_flit (head_flit),
    .vc_full   (vc_full),
    .vc_empty  (vc_empty),
    .vc_clk_en (vc_clk_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] head(input int v);
    return head_flit[v*FW +: FW];
  endfunction

  task automatic step(input logic wv, input logic [1:0] wc,
                      input logic [FW-1:0] wf, input logic [3:0] gr);
    @(negedge clk);
    in_valid = wv;
    in_vc    = wc;
    in_flit  = wf;
    rd_grant = gr;
    #1;
    en_pre = vc_clk_en;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 2'd0, '0, 4'h0);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_vc    = '0;
    in_flit  = '0;
    rd_grant = '0;
    repeat (3) @(negedge clk);
    chk("R1", "empty in reset", 64'(vc_empty), 64'hF);
    chk("R1", "full in reset", 64'(vc_full), 64'h0);
    chk("R1", "clk_en in reset", 64'(vc_clk_en), 64'h0);
    rst_n = 1'b1;
    repeat (3) idle();

    // Table walk: R2 R4 R5 R6 R9 R10 R11
    for (int i = 0; i < 18; i++) begin
      step(TBL[i].wv, TBL[i].wc, TBL[i].wf, TBL[i].gr);
      chk("R5 R6 R9 R10 R11", $sformatf("row %0d clk_en", i), 64'(en_pre), 64'(TBL[i].en));
      chk("R4", $sformatf("row %0d full", i), 64'(vc_full), 64'(TBL[i].fu));
      chk("R3 R4", $sformatf("row %0d empty", i), 64'(vc_empty), 64'(TBL[i].em));
      if (TBL[i].hk)
        chk("R2", $sformatf("row %0d head", i), 64'(head(int'(TBL[i].hv))), 64'(TBL[i].hf));
    end

    // R7: sixteen writes aimed at channel 0 spill upward in order
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 2'd0, FW'(18'h01000 + i), 4'h0);
      chk("R6 R7", $sformatf("fill %0d dest enable", i), 64'(en_pre[i/4]), 64'h1);
      if (i >= 4) chk("R7", $sformatf("fill %0d target gated", i), 64'(en_pre[0]), 64'h0);
    end
    chk("R7", "all full after spill", 64'(vc_full), 64'hF);
    chk("R7", "none empty after spill", 64'(vc_empty), 64'h0);

    // R8: write with every channel full is dropped
    step(1'b1, 2'd2, 18'h3FFFF, 4'h0);
    chk("R8", "no enable on drop", 64'(en_pre), 64'h0);
    chk("R8", "still all full", 64'(vc_full), 64'hF);
    idle();
    chk("R12", "head vc0 held", 64'(head(0)), 64'h01000);
    chk("R12", "head vc1 held", 64'(head(1)), 64'h01004);
    chk("R12", "head vc2 held", 64'(head(2)), 64'h01008);
    chk("R12", "head vc3 held", 64'(head(3)), 64'h0100C);

    // R10: read from a full channel pulses enable once
    step(1'b0, 2'd0, '0, 4'h1);
    chk("R10", "read cycle enable", 64'(en_pre), 64'h1);
    chk("R10", "full cleared", 64'(vc_full), 64'hE);
    chk("R3", "head advanced", 64'(head(0)), 64'h01001);
    idle();
    chk("R10", "stays gated after read", 64'(en_pre), 64'h0);

    // R7: wrap-around steering from channel 2 to channel 0
    step(1'b1, 2'd2, 18'h2AAAA, 4'h0);
    chk("R7", "wrap dest enable", 64'(en_pre), 64'h1);
    chk("R7", "all full after wrap", 64'(vc_full), 64'hF);
    step(1'b0, 2'd0, '0, 4'h1);
    chk("R2", "vc0 head 2", 64'(head(0)), 64'h01002);
    step(1'b0, 2'd0, '0, 4'h1);
    chk("R2", "vc0 head 3", 64'(head(0)), 64'h01003);
    step(1'b0, 2'd0, '0, 4'h1);
    chk("R7", "wrapped flit at head", 64'(head(0)), 64'h2AAAA);
    step(1'b0, 2'd0, '0, 4'h1);
    chk("R4", "vc0 empty after drain", 64'(vc_empty[0]), 64'h1);

    // R8: dropped flit never appears in channel 2
    step(1'b0, 2'd0, '0, 4'h4);
    chk("R8", "vc2 head 2", 64'(head(2)), 64'h01009);
    step(1'b0, 2'd0, '0, 4'h4);
    chk("R8", "vc2 head 3", 64'(head(2)), 64'h0100A);
    step(1'b0, 2'd0, '0, 4'h4);
    chk("R8", "vc2 head 4", 64'(head(2)), 64'h0100B);
    step(1'b0, 2'd0, '0, 4'h4);
    chk("R8", "vc2 empty after 4 reads", 64'(vc_empty[2]), 64'h1);

    // R1: asynchronous reset mid-run and synchronous release
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R1", "async empty", 64'(vc_empty), 64'hF);
    chk("R1", "async full", 64'(vc_full), 64'h0);
    chk("R1", "async clk_en", 64'(vc_clk_en), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 2'd1, 18'h0C001, 4'h0);
    chk("R1", "write ignored during release", 64'(vc_empty), 64'hF);
    step(1'b1, 2'd1, 18'h0C002, 4'h0);
    chk("R1", "write accepted after release", 64'(vc_empty), 64'hD);
    chk("R2", "first flit after reset", 64'(head(1)), 64'h0C002);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule